// File: doc/BRIEF.md
# Bidirectional Bus Direction Controller

This block decides, for every channel of a half-duplex bridge, which side's line driver is switched on. One side (A) is a single-ended bus and the other (B) is a differential bus. Both buses are active-low: a receiver output of 0 means the line is asserted and 1 means it is released. The block takes the receiver levels from both sides and produces one driver enable per side per channel. It also routes each side's received level to the opposite side's driver input. All asynchronous inputs pass through a synchronizer of `SYNC` flops before any decision uses them.

The block has two modes, chosen by `mode_shared`.

- **Per-channel mode** (`mode_shared` = 0). Each channel keeps its own direction state. The first side seen asserting takes the channel and enables the driver toward the other side. The channel is held until that originating side releases its line, so the echo of the driven line on the far side is ignored. If both sides assert in the same cycle, A wins.
- **Shared mode** (`mode_shared` = 1). One captured direction drives every channel at once. If the direction input changes, the whole bus goes quiet. The drivers come back in the new direction only once every receiver on both sides reads released.

Four active-high conditions each switch off every driver and clear all direction state:

- a bus reset request;
- a cable-mismatch sense;
- a supply-undervoltage flag;
- an overtemperature flag.

When such a condition clears, the bridge starts idle.

Top module: `busdir_ctrl`

## Requirements
- R1: Throughout and after reset (`rst_n` low), with all receivers released, every bit of `a_drv_en` and `b_drv_en` is 0.
- R2: In per-channel mode, a channel that is idle and sees `a_rx[i]`=0 sets `b_drv_en[i]`=1 and leaves `a_drv_en[i]`=0. The enable is visible after the third rising edge following the change, not after the second. A 0 on `b_rx[i]` does the mirror, setting `a_drv_en[i]`. `b_tx[i]` follows `a_rx[i]` and `a_tx[i]` follows `b_rx[i]`, each two rising edges after the input changes.
- R3: In per-channel mode, a taken channel keeps its direction while its far-side receiver reads asserted. It returns to idle, with both enables 0, once the originating side reads released.
- R4: In per-channel mode, when both sides of an idle channel assert in the same cycle, the channel takes the A-to-B direction.
- R5: For no channel are `a_drv_en[i]` and `b_drv_en[i]` both 1 in the same cycle.
- R6: In per-channel mode, channels are independent, including the top channel (index `NCH`-1) that carries parity. That channel's data is routed unchanged with no parity check, and releasing one channel does not disturb another.
- R7: On entering shared mode, `dir_shared` is captured. A value of 1 enables every B-side driver and a value of 0 enables every A-side driver.
- R8: In shared mode, two rising edges after `dir_shared` changes, every driver enable is 0. Drivers return in the new direction only after all receivers on both sides read 1.
- R9: Two rising edges after any of `bus_rst`, `cable_fault`, `uv_flag` or `ot_flag` goes high, every driver enable is 0 and all per-channel direction states are cleared.
- R10: After a clearing condition ends, or after leaving shared mode, with all receivers released, every driver enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_rx | input | NCH | A-side receiver levels, 0 = asserted |
| b_rx | input | NCH | B-side receiver levels, 0 = asserted |
| mode_shared | input | 1 | 1 selects shared-direction mode |
| dir_shared | input | 1 | Shared direction, 1 = A to B |
| bus_rst | input | 1 | Bus reset request, clears direction state |
| cable_fault | input | 1 | Cable-mismatch sense |
| uv_flag | input | 1 | Supply undervoltage flag |
| ot_flag | input | 1 | Overtemperature flag |
| a_drv_en | output | NCH | Enable for the A-side driver of each channel |
| b_drv_en | output | NCH | Enable for the B-side driver of each channel |
| a_tx | output | NCH | Level for the A-side driver (routed from B) |
| b_tx | output | NCH | Level for the B-side driver (routed from A) |

## Verification
The bench builds the block with its defaults: nine channels and a two-flop synchronizer. Nine channels put a distinct parity channel at the top index next to ordinary ones, so independence across channels and the parity path can be observed together. The two-stage synchronizer fixes latencies of two edges for routed data and clearing, and three edges for a direction grab. The bench samples exactly at those edges, so an extra or missing register stage shows up.

// File: rtl/busdir_ctrl.sv
module busdir_ctrl #(
  parameter int NCH  = 9,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] a_rx,
  input  logic [NCH-1:0] b_rx,
  input  logic           mode_shared,
  input  logic           dir_shared,
  input  logic           bus_rst,
  input  logic           cable_fault,
  input  logic           uv_flag,
  input  logic           ot_flag,
  output logic [NCH-1:0] a_drv_en,
  output logic [NCH-1:0] b_drv_en,
  output logic [NCH-1:0] a_tx,
  output logic [NCH-1:0] b_tx
);
  localparam int W = 2*NCH + 6;

  typedef enum logic [1:0] {CH_IDLE, CH_A2B, CH_B2A} ch_t;

  logic [W-1:0] raw, rst_val;
  logic [W-1:0] sy [SYNC];

  assign raw     = {ot_flag, uv_flag, cable_fault, bus_rst, dir_shared, mode_shared, b_rx, a_rx};
  assign rst_val = {6'b0, {(2*NCH){1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sy[i] <= rst_val;
    end else begin
      sy[0] <= raw;
      for (int i = 1; i < SYNC; i++) sy[i] <= sy[i-1];
    end
  end

  logic [NCH-1:0] a_s, b_s;
  logic mode_s, dir_s, clr_s, quiet;

  assign a_s    = sy[SYNC-1][NCH-1:0];
  assign b_s    = sy[SYNC-1][2*NCH-1:NCH];
  assign mode_s = sy[SYNC-1][2*NCH];
  assign dir_s  = sy[SYNC-1][2*NCH+1];
  assign clr_s  = |sy[SYNC-1][W-1:2*NCH+2];
  assign quiet  = (&a_s) & (&b_s);

  logic sh_dir, sh_valid, sh_hold, sh_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_dir   <= 1'b0;
      sh_valid <= 1'b0;
      sh_hold  <= 1'b0;
    end else if (clr_s || !mode_s) begin
      sh_valid <= 1'b0;
      sh_hold  <= 1'b0;
    end else if (!sh_valid) begin
      sh_dir   <= dir_s;
      sh_valid <= 1'b1;
      sh_hold  <= 1'b0;
    end else if (dir_s != sh_dir) begin
      sh_dir  <= dir_s;
      sh_hold <= 1'b1;
    end else if (sh_hold && quiet) begin
      sh_hold <= 1'b0;
    end
  end

  assign sh_go = mode_s & sh_valid & ~sh_hold & (dir_s == sh_dir) & ~clr_s;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ch_t st;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= CH_IDLE;
      end else if (clr_s || mode_s) begin
        st <= CH_IDLE;
      end else begin
        case (st)
          CH_IDLE: begin
            if (!a_s[g])      st <= CH_A2B;
            else if (!b_s[g]) st <= CH_B2A;
          end
          CH_A2B:  if (a_s[g]) st <= CH_IDLE;
          CH_B2A:  if (b_s[g]) st <= CH_IDLE;
          default: st <= CH_IDLE;
        endcase
      end
    end

    assign b_drv_en[g] = ~clr_s & (mode_s ? (sh_go &  sh_dir) : (st == CH_A2B));
    assign a_drv_en[g] = ~clr_s & (mode_s ? (sh_go & ~sh_dir) : (st == CH_B2A));
  end

  assign b_tx = a_s;
  assign a_tx = b_s;
endmodule

module busdir_ctrl_chk #(
  parameter int NCH  = 9,
  parameter int SYNC = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] a_rx,
  input logic [NCH-1:0] b_rx,
  input logic           mode_shared,
  input logic           dir_shared,
  input logic           bus_rst,
  input logic           cable_fault,
  input logic           uv_flag,
  input logic           ot_flag,
  input logic [NCH-1:0] a_drv_en,
  input logic [NCH-1:0] b_drv_en,
  input logic [NCH-1:0] a_tx,
  input logic [NCH-1:0] b_tx
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv_en & b_drv_en) == '0);

  if (SYNC == 2) begin : g_lat
    // R9
    clear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rst | cable_fault | uv_flag | ot_flag, 2) |-> (a_drv_en | b_drv_en) == '0);

    // R8
    dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_shared, 2) && ($past(dir_shared, 2) != $past(dir_shared, 3)))
        |-> (a_drv_en | b_drv_en) == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_grab
      // R2
      grab_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(b_drv_en[g]) && !$past(mode_shared, 3)) |-> !$past(a_rx[g], 3));
    end
  end
endmodule

bind busdir_ctrl busdir_ctrl_chk #(.NCH(NCH), .SYNC(SYNC)) u_chk (.*);

// File: tb/busdir_ctrl_tb.sv
module busdir_ctrl_tb;
  localparam int NCH = 9;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] a_rx = '1, b_rx = '1;
  logic mode_shared = 1'b0, dir_shared = 1'b0;
  logic bus_rst = 1'b0, cable_fault = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
  logic [NCH-1:0] a_drv_en, b_drv_en, a_tx, b_tx;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  busdir_ctrl #(.NCH(NCH), .SYNC(2)) u_dut (.*);

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic set_clear(int k, logic v);
    case (k)
      0: bus_rst = v;
      1: cable_fault = v;
      2: uv_flag = v;
      default: ot_flag = v;
    endcase
  endtask

  task automatic t_reset;
    tick(1);
    chk("R1 a_en in reset", a_drv_en, 0);
    chk("R1 b_en in reset", b_drv_en, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 a_en after reset", a_drv_en, 0);
    chk("R1 b_en after reset", b_drv_en, 0);
  endtask

  task automatic t_grab_release;
    a_rx[2] = 1'b0;
    tick(2);
    chk("R2 no enable at edge 2", b_drv_en, 0);
    chk("R2 data routed to B", b_tx[2], 0);
    tick(1);
    chk("R2 B enable at edge 3", b_drv_en, 9'h004);
    chk("R2 A enable stays off", a_drv_en, 0);
    b_rx[2] = 1'b0;
    tick(4);
    chk("R3 echo ignored b_en", b_drv_en, 9'h004);
    chk("R3 echo ignored a_en", a_drv_en, 0);
    a_rx[2] = 1'b1; b_rx[2] = 1'b1;
    tick(3);
    chk("R3 released b_en", b_drv_en, 0);
    chk("R3 released a_en", a_drv_en, 0);
  endtask

  task automatic t_independent;
    b_rx[5] = 1'b0; a_rx[8] = 1'b0;
    tick(3);
    chk("R2 B grabs ch5", a_drv_en, 9'h020);
    chk("R6 parity ch A to B", b_drv_en, 9'h100);
    chk("R6 parity data", b_tx[8], 0);
    chk("R2 data routed to A", a_tx[5], 0);
    a_rx[8] = 1'b1;
    tick(3);
    chk("R6 parity released", b_drv_en, 0);
    chk("R6 ch5 undisturbed", a_drv_en, 9'h020);
    b_rx[5] = 1'b1;
    tick(3);
    chk("R3 ch5 released", a_drv_en, 0);
  endtask

  task automatic t_tie;
    a_rx[0] = 1'b0; b_rx[0] = 1'b0;
    tick(3);
    chk("R4 tie A wins b_en", b_drv_en, 9'h001);
    chk("R4 tie a_en off", a_drv_en, 0);
    a_rx[0] = 1'b1; b_rx[0] = 1'b1;
    tick(3);
    chk("R4 tie released", b_drv_en | a_drv_en, 0);
  endtask

  task automatic t_clears;
    for (int k = 0; k < 4; k++) begin
      a_rx[1] = 1'b0;
      tick(3);
      chk("R9 latched before clear", b_drv_en, 9'h002);
      set_clear(k, 1'b1);
      tick(2);
      chk("R9 drivers off", a_drv_en | b_drv_en, 0);
      a_rx[1] = 1'b1;
      tick(2);
      set_clear(k, 1'b0);
      tick(5);
      chk("R10 idle after clear", a_drv_en | b_drv_en, 0);
    end
  endtask

  task automatic t_shared;
    dir_shared = 1'b1; mode_shared = 1'b1;
    tick(4);
    chk("R7 all B enabled", b_drv_en, 9'h1FF);
    chk("R7 no A enabled", a_drv_en, 0);
    a_rx = 9'h0A5;
    tick(2);
    chk("R7 data to B", b_tx, 9'h0A5);
    a_rx = '1; b_rx[3] = 1'b0;
    tick(2);
    dir_shared = 1'b0;
    tick(2);
    chk("R8 quiet at edge 2", a_drv_en | b_drv_en, 0);
    tick(5);
    chk("R8 held while line busy", a_drv_en | b_drv_en, 0);
    b_rx[3] = 1'b1;
    tick(3);
    chk("R8 A side enabled", a_drv_en, 9'h1FF);
    chk("R8 B side off", b_drv_en, 0);
    ot_flag = 1'b1;
    tick(2);
    chk("R9 shared drivers off", a_drv_en | b_drv_en, 0);
    ot_flag = 1'b0;
    mode_shared = 1'b0;
    tick(5);
    chk("R10 idle after leaving shared", a_drv_en | b_drv_en, 0);
  endtask

  initial begin
    t_reset();
    t_grab_release();
    t_independent();
    t_tie();
    t_clears();
    t_shared();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule